// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the register file of a 16450/8250-class serial port as seen by a simple byte-wide host bus. The host reaches it through a 3-bit offset with separate read and write strobes. Bit 7 of the line control register switches offsets 0 and 1 between two sets of registers. When the bit is clear they reach the data path and the interrupt enable register. When it is set they reach the two divisor bytes. On the data side, a received byte arrives on a parallel input together with an availability flag. The block pulses a take strobe when the host consumes that byte. A byte the host writes leaves on a parallel output with a one-cycle valid pulse.

Interrupts are not raised at once. Each source, receive data and transmit holding empty, owns a countdown timer. A timer is started, restarted from its full count, or cancelled by the register accesses that concern its source. When a timer runs out, the single level interrupt output is raised and the source is marked pending, but only if that source is still enabled at that moment. The identification register reports the pending source, with receive ranking above transmit. The line status register always shows an idle transmitter. The scratch, modem status and FIFO control locations are inert. A modem control write of 0x1A raises a loopback-test indication.

Top module: `sio_regs`

## Requirements
- R1: After synchronous reset the interrupt enable, line control, modem control and divisor registers read zero, both timers are idle, `irq` and `tx_valid` are low, and the identification register reads 0x01.
- R2: While line control bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. A write there emits no transmit byte and leaves the interrupt enable register unchanged.
- R3: A read of offset 0 with line control bit 7 clear returns `rx_byte` and pulses `rx_take` in the same cycle when `rx_avail` is high. Otherwise it returns 0x00 and `rx_take` stays low.
- R4: Such a receive read lowers `irq` and clears the receive pending mark. On the next clock edge, if `rx_avail` is high and interrupt enable bit 0 (receive) is set, the receive timer restarts.
- R5: A write of offset 0 with line control bit 7 clear puts the byte on `tx_byte` with `tx_valid` high for exactly the cycle after the write edge. It lowers `irq`, clears the transmit pending mark, and restarts the transmit timer when interrupt enable bit 1 (transmit) is set.
- R6: A write of the interrupt enable register (offset 1, low 4 bits stored) has these effects. If bit 1 is set, the transmit timer restarts; if bit 1 is clear, the transmit timer is cancelled, the transmit pending mark is cleared and `irq` is lowered. If bit 0 is set and `rx_avail` is high, the receive timer restarts; otherwise the receive timer is cancelled, the receive pending mark is cleared and `irq` is lowered.
- R7: A timer started at clock edge k expires at edge k+IRQ_DELAY. Restarting it starts a new full count. On expiry, `irq` goes high and the source is marked pending only if its enable bit is set at that edge.
- R8: The identification register (offset 2) reads 0x04 when a receive interrupt is pending, otherwise 0x02 when a transmit interrupt is pending, otherwise 0x01. Reading it while it shows 0x02 clears the transmit pending mark.
- R9: The line status register (offset 5) reads 0x60 with bit 0 equal to `rx_avail`.
- R10: Offsets 4, 6 and 7 read 0x00. Writes to offsets 2 and 7 change nothing readable.
- R11: The line control register (offset 3) reads back all 8 bits written. `loop_test` is high exactly while the last modem control write (offset 4) was 0x1A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, side effects on the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| rx_byte | input | 8 | Byte offered by the receive stream |
| rx_avail | input | 1 | Receive byte available |
| rx_take | output | 1 | Receive byte consumed this cycle |
| tx_byte | output | 8 | Transmitted byte |
| tx_valid | output | 1 | One-cycle transmit pulse |
| irq | output | 1 | Level interrupt request |
| loop_test | output | 1 | Loopback-test request indication |

## Verification
Read data and `rx_take` are due in the same cycle as the strobe, so the bench samples them one nanosecond after the falling edge on which it drives the strobe. `tx_valid` is due one edge after the write, and a timer started at edge k raises `irq` at edge k+IRQ_DELAY. A receive read restarts the receive timer one edge later than the read itself, so the rise follows that read at edge k+1+IRQ_DELAY. A reference model updated on every rising edge predicts `irq`, the transmit output and the read value. These are compared at each falling edge. Dedicated checks also count the cycles up to each interrupt rise and confirm that `irq` is still low one cycle before it.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned IEN_W   = 4;
    localparam int unsigned N_SRC   = 2;

    localparam int unsigned SRC_RX  = 0;
    localparam int unsigned SRC_TX  = 1;
    localparam int unsigned DLAB_BIT = 7;

    localparam logic [DATA_W-1:0] LOOP_CODE  = 8'h1A;
    localparam logic [DATA_W-1:0] IDENT_NONE = 8'h01;
    localparam logic [DATA_W-1:0] IDENT_TX   = 8'h02;
    localparam logic [DATA_W-1:0] IDENT_RX   = 8'h04;
    localparam logic [DATA_W-1:0] LSTAT_IDLE = 8'h60;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA    = 3'd0,
        OFS_IEN     = 3'd1,
        OFS_IDENT   = 3'd2,
        OFS_LINE    = 3'd3,
        OFS_MODEM   = 3'd4,
        OFS_LSTAT   = 3'd5,
        OFS_MSTAT   = 3'd6,
        OFS_SCRATCH = 3'd7
    } ofs_e;

    typedef struct packed {
        logic rx_rd;
        logic tx_wr;
        logic dll_wr;
        logic dlm_wr;
        logic ien_wr;
        logic lcr_wr;
        logic mcr_wr;
        logic ident_rd;
    } access_t;

    function automatic byte_t ident_code(input logic rx_pend, input logic tx_pend);
        if (rx_pend)      return IDENT_RX;
        else if (tx_pend) return IDENT_TX;
        else              return IDENT_NONE;
    endfunction

    function automatic byte_t lstat_code(input logic avail);
        return LSTAT_IDLE | byte_t'(avail);
    endfunction

endpackage

// File: rtl/sio_decode.sv
module sio_decode
    import sio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              dlab,
    output access_t           acc
);
    ofs_e ofs;

    always_comb begin
        ofs          = ofs_e'(addr);
        acc          = '0;
        acc.rx_rd    = rd && (ofs == OFS_DATA)  && !dlab;
        acc.tx_wr    = wr && (ofs == OFS_DATA)  && !dlab;
        acc.dll_wr   = wr && (ofs == OFS_DATA)  &&  dlab;
        acc.dlm_wr   = wr && (ofs == OFS_IEN)   &&  dlab;
        acc.ien_wr   = wr && (ofs == OFS_IEN)   && !dlab;
        acc.lcr_wr   = wr && (ofs == OFS_LINE);
        acc.mcr_wr   = wr && (ofs == OFS_MODEM);
        acc.ident_rd = rd && (ofs == OFS_IDENT);
    end
endmodule

// File: rtl/sio_irq_timer.sv
module sio_irq_timer #(
    parameter int unsigned DELAY = 450
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic cancel,
    output logic fire
);
    localparam int unsigned CNT_W = $clog2(DELAY + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign fire = run_q && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (cancel) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (arm) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(DELAY);
        end else if (run_q) begin
            if (cnt_q == CNT_W'(1)) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sio_regs.sv
module sio_regs
    import sio_pkg::*;
#(
    parameter int unsigned IRQ_DELAY = 450
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  rx_byte,
    input  logic        rx_avail,
    output logic        rx_take,
    output logic [7:0]  tx_byte,
    output logic        tx_valid,
    output logic        irq,
    output logic        loop_test
);
    access_t          acc;
    logic [IEN_W-1:0] ier_q;
    byte_t            lcr_q;
    byte_t            mcr_q;
    byte_t            dll_q;
    byte_t            dlm_q;
    logic [N_SRC-1:0] pend_q;
    logic             irq_q;
    logic             rechk_q;
    byte_t            tx_byte_q;
    logic             tx_valid_q;

    logic [N_SRC-1:0] t_arm;
    logic [N_SRC-1:0] t_cancel;
    logic [N_SRC-1:0] t_fire;

    logic             dlab;
    logic             new_rx_on;
    logic             new_tx_on;

    assign dlab      = lcr_q[DLAB_BIT];
    assign new_rx_on = bus_wdata[SRC_RX] && rx_avail;
    assign new_tx_on = bus_wdata[SRC_TX];

    sio_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .dlab (dlab),
        .acc  (acc)
    );

    // Per-source start / stop requests
    assign t_arm[SRC_RX]    = (rechk_q && rx_avail && ier_q[SRC_RX])
                            || (acc.ien_wr && new_rx_on);
    assign t_cancel[SRC_RX] = acc.ien_wr && !new_rx_on;
    assign t_arm[SRC_TX]    = (acc.ien_wr && new_tx_on)
                            || (acc.tx_wr && ier_q[SRC_TX]);
    assign t_cancel[SRC_TX] = acc.ien_wr && !new_tx_on;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        sio_irq_timer #(.DELAY(IRQ_DELAY)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .arm    (t_arm[s]),
            .cancel (t_cancel[s]),
            .fire   (t_fire[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q      <= '0;
            lcr_q      <= '0;
            mcr_q      <= '0;
            dll_q      <= '0;
            dlm_q      <= '0;
            pend_q     <= '0;
            irq_q      <= 1'b0;
            rechk_q    <= 1'b0;
            tx_byte_q  <= '0;
            tx_valid_q <= 1'b0;
        end else begin
            // expiry first; bus side effects below take precedence
            for (int s = 0; s < N_SRC; s++) begin
                if (t_fire[s] && ier_q[s]) begin
                    irq_q     <= 1'b1;
                    pend_q[s] <= 1'b1;
                end
            end

            rechk_q    <= acc.rx_rd;
            tx_valid_q <= acc.tx_wr;

            if (acc.rx_rd) begin
                irq_q          <= 1'b0;
                pend_q[SRC_RX] <= 1'b0;
            end

            if (acc.ident_rd && !pend_q[SRC_RX] && pend_q[SRC_TX])
                pend_q[SRC_TX] <= 1'b0;

            if (acc.tx_wr) begin
                tx_byte_q      <= bus_wdata;
                irq_q          <= 1'b0;
                pend_q[SRC_TX] <= 1'b0;
            end

            if (acc.dll_wr) dll_q <= bus_wdata;
            if (acc.dlm_wr) dlm_q <= bus_wdata;
            if (acc.lcr_wr) lcr_q <= bus_wdata;
            if (acc.mcr_wr) mcr_q <= bus_wdata;

            if (acc.ien_wr) begin
                ier_q <= bus_wdata[IEN_W-1:0];
                if (t_cancel[SRC_TX]) begin
                    pend_q[SRC_TX] <= 1'b0;
                    irq_q          <= 1'b0;
                end
                if (t_cancel[SRC_RX]) begin
                    pend_q[SRC_RX] <= 1'b0;
                    irq_q          <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        unique case (ofs_e'(bus_addr))
            OFS_DATA:    bus_rdata = dlab ? dll_q : (rx_avail ? rx_byte : '0);
            OFS_IEN:     bus_rdata = dlab ? dlm_q : byte_t'(ier_q);
            OFS_IDENT:   bus_rdata = ident_code(pend_q[SRC_RX], pend_q[SRC_TX]);
            OFS_LINE:    bus_rdata = lcr_q;
            OFS_LSTAT:   bus_rdata = lstat_code(rx_avail);
            OFS_MODEM,
            OFS_MSTAT,
            OFS_SCRATCH: bus_rdata = '0;
            default:     bus_rdata = '0;
        endcase
    end

    assign rx_take   = acc.rx_rd && rx_avail;
    assign tx_byte   = tx_byte_q;
    assign tx_valid  = tx_valid_q;
    assign irq       = irq_q;
    assign loop_test = (mcr_q == LOOP_CODE);

endmodule

// File: rtl/sio_regs_chk.sv
module sio_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       rx_avail,
    input logic       rx_take,
    input logic       tx_valid,
    input logic       irq,
    input logic [3:0] ien,
    input logic [7:0] lcr
);
    // R1
    a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    // R3
    a_r3_take_needs_read_and_data: assert property (@(posedge clk) disable iff (rst)
        rx_take |-> (bus_rd && rx_avail && bus_addr == 3'd0 && !lcr[7]));

    // R5
    a_r5_tx_follows_write: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_wr && bus_addr == 3'd0 && !lcr[7]));

    // R6
    a_r6_disable_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1 && !lcr[7] && bus_wdata[1:0] == 2'b00) |=> !irq);

    // R7
    a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ien[0] || ien[1]));

    // R8
    a_r8_ident_legal: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd2) |-> (bus_rdata == 8'h01 || bus_rdata == 8'h02 || bus_rdata == 8'h04));

    // R9
    a_r9_line_status: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd5) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == rx_avail));

    // R10
    a_r10_scratch_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd7) |-> (bus_rdata == 8'h00));
endmodule

bind sio_regs sio_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_avail  (rx_avail),
    .rx_take   (rx_take),
    .tx_valid  (tx_valid),
    .irq       (irq),
    .ien       (ier_q),
    .lcr       (lcr_q)
);

// File: tb/sim_sio_regs.sv
`timescale 1ns/1ps
module sim_sio_regs;
    localparam int D = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rx_byte = '0;
    logic       rx_avail = 1'b0;
    logic       rx_take;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       irq;
    logic       loop_test;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sio_regs #(.IRQ_DELAY(D)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte(rx_byte),
        .rx_avail(rx_avail), .rx_take(rx_take), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .irq(irq), .loop_test(loop_test)
    );

    // ---------------- reference model ----------------
    int   m_rxc, m_txc;
    bit   m_irq, m_prx, m_ptx, m_rechk, m_txv, m_loop;
    bit [3:0] m_ier;
    bit [7:0] m_lcr, m_dll, m_dlm, m_txb;

    function automatic bit [7:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? m_dll : (rx_avail ? rx_byte : 8'h00);
            3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
            3'd2: return m_prx ? 8'h04 : (m_ptx ? 8'h02 : 8'h01);
            3'd3: return m_lcr;
            3'd5: return 8'h60 | {7'h0, rx_avail};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        bit o_prx, o_ptx, o_rechk, f_rx, f_tx;
        bit [3:0] o_ier;
        bit [7:0] o_lcr;
        if (rst) begin
            m_rxc = 0; m_txc = 0; m_irq = 0; m_prx = 0; m_ptx = 0; m_rechk = 0;
            m_txv = 0; m_loop = 0; m_ier = 0; m_lcr = 0; m_dll = 0; m_dlm = 0; m_txb = 0;
        end else begin
            o_prx = m_prx; o_ptx = m_ptx; o_rechk = m_rechk; o_ier = m_ier; o_lcr = m_lcr;
            f_rx = (m_rxc == 1); f_tx = (m_txc == 1);
            if (m_rxc > 0) m_rxc--;
            if (m_txc > 0) m_txc--;
            if (f_rx && o_ier[0]) begin m_irq = 1; m_prx = 1; end
            if (f_tx && o_ier[1]) begin m_irq = 1; m_ptx = 1; end
            m_txv = 0; m_rechk = 0;
            if (o_rechk && rx_avail && o_ier[0]) m_rxc = D;
            if (bus_rd && bus_addr == 0 && !o_lcr[7]) begin m_irq = 0; m_prx = 0; m_rechk = 1; end
            if (bus_rd && bus_addr == 2 && !o_prx && o_ptx) m_ptx = 0;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: if (o_lcr[7]) m_dll = bus_wdata;
                          else begin
                              m_txv = 1; m_txb = bus_wdata; m_irq = 0; m_ptx = 0;
                              if (o_ier[1]) m_txc = D;
                          end
                    3'd1: if (o_lcr[7]) m_dlm = bus_wdata;
                          else begin
                              m_ier = bus_wdata[3:0];
                              if (bus_wdata[1]) m_txc = D;
                              else begin m_txc = 0; m_ptx = 0; m_irq = 0; end
                              if (bus_wdata[0] && rx_avail) m_rxc = D;
                              else begin m_rxc = 0; m_prx = 0; m_irq = 0; end
                          end
                    3'd3: m_lcr = bus_wdata;
                    3'd4: m_loop = (bus_wdata == 8'h1A);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R4 R5 R7 R8 R11)
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R7 irq model", irq, m_irq);
            check("R5 tx_valid model", tx_valid, m_txv);
            if (m_txv) check("R5 tx_byte model", tx_byte, m_txb);
            check("R8 rdata model", bus_rdata, m_read(bus_addr));
            check("R11 loop model", loop_test, m_loop);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v, output logic tk,
                      input logic navail, input logic [7:0] nbyte);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = bus_rdata; tk = rx_take;
        @(negedge clk);
        bus_rd = 1'b0; rx_avail = navail; rx_byte = nbyte;
    endtask

    task automatic rdq(input logic [2:0] a, output logic [7:0] v);
        logic tk;
        rd(a, v, tk, rx_avail, rx_byte);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic tk;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rdq(3'd3, v); check("R1 lcr", v, 8'h00);
        rdq(3'd1, v); check("R1 ier", v, 8'h00);
        rdq(3'd2, v); check("R1 ident", v, 8'h01);
        check("R1 irq", irq, 0);
        check("R1 tx_valid", tx_valid, 0);

        // R11 line control and loopback
        wr(3'd3, 8'h1B); rdq(3'd3, v); check("R11 lcr readback", v, 8'h1B);
        wr(3'd4, 8'h1A); check("R11 loop set", loop_test, 1);
        rdq(3'd4, v); check("R10 modem ctl reads zero", v, 8'h00);
        wr(3'd4, 8'h1B); check("R11 loop clear", loop_test, 0);

        // R2 divisor latch
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34); check("R2 no tx on dll write", tx_valid, 0);
        wr(3'd1, 8'h12);
        rdq(3'd0, v); check("R2 dll", v, 8'h34);
        rdq(3'd1, v); check("R2 dlm", v, 8'h12);
        wr(3'd3, 8'h03);
        rdq(3'd1, v); check("R2 ier untouched", v, 8'h00);

        // R9 line status
        rdq(3'd5, v); check("R9 lsr empty", v, 8'h60);
        @(negedge clk); rx_avail = 1'b1; rx_byte = 8'hA5;
        rdq(3'd5, v); check("R9 lsr ready", v, 8'h61);

        // R3 receive read
        rd(3'd0, v, tk, 1'b0, 8'h00); check("R3 rx byte", v, 8'hA5); check("R3 take", tk, 1);
        rd(3'd0, v, tk, 1'b0, 8'h00); check("R3 empty zero", v, 8'h00); check("R3 no take", tk, 0);

        // R6 R7 transmit enable, exact expiry time
        wr(3'd1, 8'h02);
        idle(D - 1); check("R7 not yet", irq, 0);
        idle(1);     check("R7 expiry", irq, 1);
        rdq(3'd2, v); check("R8 tx ident", v, 8'h02);
        rdq(3'd2, v); check("R8 tx cleared by ident read", v, 8'h01);
        check("R8 irq stays", irq, 1);

        // R5 transmit write
        wr(3'd0, 8'h5A);
        check("R5 tx_valid", tx_valid, 1); check("R5 tx_byte", tx_byte, 8'h5A);
        check("R5 irq dropped", irq, 0);
        idle(1); check("R5 one cycle pulse", tx_valid, 0);
        idle(D - 2); check("R5 rearm not yet", irq, 0);
        idle(1); check("R5 rearm expiry", irq, 1);

        // R6 cancel
        wr(3'd1, 8'h00); check("R6 disable drops irq", irq, 0);
        wr(3'd1, 8'h02); idle(4); wr(3'd1, 8'h00);
        idle(D + 2); check("R6 cancelled timer silent", irq, 0);

        // R7 restart from full count
        wr(3'd1, 8'h02); idle(5); wr(3'd1, 8'h02);
        idle(D - 1); check("R7 restart not yet", irq, 0);
        idle(1); check("R7 restart expiry", irq, 1);

        // R8 priority, R4 receive read rearm
        wr(3'd1, 8'h00);
        @(negedge clk); rx_avail = 1'b1; rx_byte = 8'h3C;
        wr(3'd1, 8'h03);
        idle(D); check("R7 both expire", irq, 1);
        rdq(3'd2, v); check("R8 rx priority", v, 8'h04);
        rd(3'd0, v, tk, 1'b1, 8'h3D); check("R3 rx byte 2", v, 8'h3C);
        check("R4 irq dropped", irq, 0);
        rdq(3'd2, v); check("R4 rx pending cleared", v, 8'h02);
        idle(2 * D); check("R4 rearm fired", irq, 1);
        rdq(3'd2, v); check("R4 rx pending again", v, 8'h04);

        // R10 inert locations
        wr(3'd7, 8'hAA); rdq(3'd7, v); check("R10 scratch", v, 8'h00);
        rdq(3'd6, v); check("R10 modem status", v, 8'h00);
        wr(3'd2, 8'hC7); rdq(3'd2, v); check("R10 fifo write ignored", v, 8'h04);
        rdq(3'd3, v); check("R10 lcr unchanged", v, 8'h03);

        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule